// File: doc/BRIEF.md
# Masked Input-Change Interrupt Unit

This unit raises the shared interrupt line of a 16-pin I/O expander when an input pin no longer agrees with the value the host last read from that pin's port. The pins arrive asynchronously and are first resynchronised through a short flop chain. Each pin configured as an input is then compared with its bit in the captured input register. A host read of a port, signalled by a one-cycle strobe, loads that port's current pin values into the captured register. This removes the mismatch for that port.

Each pin has a mask bit and a latch-enable bit. A masked pin never raises the interrupt, and its status bit always reads 0. When latching is enabled, a brief excursion of a pin is remembered as a pending source until the port is read, even if the pin has already returned to its captured level. The interrupt output is an enable for pulling the line low, so it suits an open-drain pad. It is registered from the OR of all status bits.

The mask, latch and direction settings are held elsewhere and are wired in. At reset they are expected to be in their power-up state: all pins masked, all pins inputs.

Top module: `pin_change_irq`

## Requirements
- R1: `irq_drive_low` is 1 in the cycle after any bit of `irq_status` is 1, and 0 in the cycle after all bits of `irq_status` are 0.
- R2: Pin i is a source when `pin_dir_in[i]` is 1 (input) and its synchronised value differs from `in_port_q[i]`. In that case `irq_status[i]` is 1 unless the pin is masked.
- R3: While `irq_mask[i]` is 1, `irq_status[i]` reads 0. With all mask bits at 1, `irq_drive_low` stays 0 whatever the pins do.
- R4: A pin with `pin_dir_in[i]` = 0 (output) never sets its status bit or raises the interrupt, however its pin toggles.
- R5: `port_rd[p]` high at a clock edge loads synchronised pins 8p..8p+7 into `in_port_q[8p+7:8p]`. The other port's bits are unchanged. Port 0 is bits 7..0 and port 1 is bits 15..8.
- R6: With `latch_en[i]` = 1, a mismatch lasting one cycle keeps `irq_status[i]` at 1 after the pin returns, and `in_port_q[i]` stays frozen, until port read.
- R7: With `latch_en[i]` = 0, `irq_status[i]` follows the mismatch and drops once the pin returns to its captured level.
- R8: A change on `pin_async` is reflected in `irq_status` after exactly two clock edges.
- R9: After synchronous reset, `in_port_q`, `irq_status` and `irq_drive_low` are all 0.
- R10: After the edge that takes a clearing read, the port's status bits are 0. `irq_drive_low` falls one edge later if no other source remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_async | input | 16 | Raw pin levels, asynchronous |
| pin_dir_in | input | 16 | 1 = pin is an input and takes part in detection |
| irq_mask | input | 16 | 1 = pin masked |
| latch_en | input | 16 | 1 = hold a change until the port is read |
| port_rd | input | 2 | One-cycle read strobe per port |
| irq_drive_low | output | 1 | 1 = pull the interrupt line low |
| in_port_q | output | 16 | Captured input register |
| irq_status | output | 16 | Per-pin interrupt source status |

## Verification
The assertions take for granted that a read strobe is a level seen at clock edges and that mask, direction and latch settings are stable across each edge. They also assume the mask is all ones while reset is applied. The stimulus changes every input shortly after the falling edge. It holds mask, direction and latch fixed for long runs and changes them only now and then. It toggles pins and issues reads at low random rates, so that latched, masked and output pins are all seen, both with and without pending changes. The stimulus keeps each latched pulse at least one full cycle wide, so that it survives the synchroniser.

// File: rtl/pin_change_irq_pkg.sv
// Package: shared defaults for the input-change interrupt unit.
// Assumes: a port is a byte-wide group of pins read by one strobe.
package pin_change_irq_pkg;
    localparam int DEF_PORTS = 2;
    localparam int DEF_PORT_W = 8;
    localparam int DEF_SYNC = 2;
endpackage

// File: rtl/chg_sync.sv
// Module: chg_sync
// Resynchronises asynchronous pins through a chain of STAGES flops.
// Assumes: each pin is treated independently, and no bus coherency is needed.
module chg_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stg [STAGES];

    // Purpose: shift pin levels down the chain each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/chg_port_slice.sv
// Module: chg_port_slice
// For one port: holds the captured input value and the latched pending sources,
// and produces the masked per-pin status.
// Assumes: rd is a single-cycle strobe; settings are stable around each edge.
module chg_port_slice #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_sync,
    input  logic [W-1:0] dir_in,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] latch,
    input  logic         rd,
    output logic [W-1:0] cap_q,
    output logic [W-1:0] status
);
    logic [W-1:0] held_q;
    logic [W-1:0] diff;
    logic [W-1:0] src;

    // Purpose: live mismatch on input pins.
    always_comb diff = dir_in & (pin_sync ^ cap_q);

    // Purpose: a pin is a source if mismatched now or holding a latched change.
    always_comb src = dir_in & (diff | held_q);

    // Purpose: hide masked pins from the status.
    always_comb status = src & ~mask;

    // Purpose: capture the port on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  cap_q <= '0;
        else if (rd) cap_q <= pin_sync;
    end

    // Purpose: remember transient changes on latched pins until the port is read.
    always_ff @(posedge clk) begin
        if (!rst_n)  held_q <= '0;
        else if (rd) held_q <= '0;
        else         held_q <= latch & (held_q | diff);
    end

    // R5: a read loads exactly the synchronised pins seen at that edge
    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (cap_q == $past(pin_sync)));

    // R6: a latched pending change survives any cycle without a read
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (($past(held_q) & $past(latch) & ~held_q) == '0));

    // R10: after a read, with pins unchanged, the port reports no source
    p_rd_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (((pin_sync ^ cap_q) != '0) || (status == '0)));
endmodule

// File: rtl/chg_irq_drive.sv
// Module: chg_irq_drive
// Registers the OR of all status bits into a glitch-free pull-low enable.
// Assumes: the enable drives an open-drain pad outside this block.
module chg_irq_drive #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status_all,
    output logic         irq_q
);
    // Purpose: register the reduced status.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |status_all;
    end

    // R1: any status bit raises the line on the next cycle
    p_irq_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|status_all) |=> irq_q);

    // R1: no status bit releases the line on the next cycle
    p_irq_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(|status_all) |=> !irq_q);
endmodule

// File: rtl/pin_change_irq.sv
// Module: pin_change_irq (top)
// Input-change interrupt for an expander: synchroniser, one slice per port,
// and a registered pull-low enable.
// Assumes: mask/direction/latch settings are held outside; all masked at reset.
module pin_change_irq
    import pin_change_irq_pkg::*;
#(
    parameter int NUM_PORTS   = DEF_PORTS,
    parameter int PORT_W      = DEF_PORT_W,
    parameter int SYNC_STAGES = DEF_SYNC
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS*PORT_W-1:0]   pin_async,
    input  logic [NUM_PORTS*PORT_W-1:0]   pin_dir_in,
    input  logic [NUM_PORTS*PORT_W-1:0]   irq_mask,
    input  logic [NUM_PORTS*PORT_W-1:0]   latch_en,
    input  logic [NUM_PORTS-1:0]          port_rd,
    output logic                          irq_drive_low,
    output logic [NUM_PORTS*PORT_W-1:0]   in_port_q,
    output logic [NUM_PORTS*PORT_W-1:0]   irq_status
);
    localparam int NPINS = NUM_PORTS * PORT_W;

    logic [NPINS-1:0] pin_sync;

    chg_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_async),
        .q_sync  (pin_sync)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        chg_port_slice #(.W(PORT_W)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_sync (pin_sync[p*PORT_W +: PORT_W]),
            .dir_in   (pin_dir_in[p*PORT_W +: PORT_W]),
            .mask     (irq_mask[p*PORT_W +: PORT_W]),
            .latch    (latch_en[p*PORT_W +: PORT_W]),
            .rd       (port_rd[p]),
            .cap_q    (in_port_q[p*PORT_W +: PORT_W]),
            .status   (irq_status[p*PORT_W +: PORT_W])
        );
    end

    chg_irq_drive #(.W(NPINS)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_all (irq_status),
        .irq_q      (irq_drive_low)
    );

    // R3: a fully masked unit keeps the line released
    p_all_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((&irq_mask) && $past(&irq_mask)) |-> !irq_drive_low);

    // R4: output pins never appear as sources
    p_out_pin_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status & ~pin_dir_in) == '0);
endmodule

// File: tb/tb_pin_change_irq.sv
module tb_pin_change_irq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] pin, dir, mask, latch;
    logic [1:0]  rd;
    logic        irq;
    logic [15:0] inq, stat;

    int n_chk = 0, n_bad = 0;
    bit auto_on = 0, done = 0;

    always #5 clk = ~clk;

    pin_change_irq dut (
        .clk(clk), .rst_n(rst_n), .pin_async(pin), .pin_dir_in(dir),
        .irq_mask(mask), .latch_en(latch), .port_rd(rd),
        .irq_drive_low(irq), .in_port_q(inq), .irq_status(stat)
    );

    // reference model built from the requirements
    logic [15:0] m_s1, m_s2, m_in, m_held;
    logic        m_irq;

    function automatic logic [15:0] exp_status(input logic [15:0] s2, cap, held,
                                               d, msk);
        logic [15:0] diff;
        diff = d & (s2 ^ cap);
        return d & (diff | held) & ~msk;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_in <= '0; m_held <= '0; m_irq <= 1'b0;
        end else begin
            logic [15:0] rdm;
            rdm = {{8{rd[1]}}, {8{rd[0]}}};
            m_s1   <= pin;
            m_s2   <= m_s1;
            m_in   <= (rdm & m_s2) | (~rdm & m_in);
            m_held <= ~rdm & latch & (m_held | (dir & (m_s2 ^ m_in)));
            m_irq  <= |exp_status(m_s2, m_in, m_held, dir, mask);
        end
    end

    task automatic check(input string tag, input logic [15:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (auto_on && rst_n && !done) begin
            check("R2 status", stat, exp_status(m_s2, m_in, m_held, dir, mask));
            check("R1 irq", {15'd0, irq}, {15'd0, m_irq});
            check("R5 capture", inq, m_in);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic next_cycle();
        @(negedge clk); #1;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; pin = '0; dir = '1; mask = '1; latch = '0; rd = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 in_port_q", inq, 16'h0000);
        check("R9 status", stat, 16'h0000);
        check("R9 irq", {15'd0, irq}, 16'h0000);
        #1 rst_n = 1;
        auto_on = 1;

        // R3: everything masked, pins toggle, line stays released
        for (int i = 0; i < 6; i++) begin
            next_cycle(); pin = 16'hA5C3 ^ 16'(i * 16'h1111);
        end
        repeat (3) @(negedge clk);
        check("R3 masked status", stat, 16'h0000);
        check("R3 masked irq", {15'd0, irq}, 16'h0000);

        // clean start: pins low and both ports read
        #1 pin = '0;
        repeat (3) next_cycle();
        rd = 2'b11; next_cycle(); rd = 2'b00;

        // R8 / R1 / R7: unmasked pin 3, no latch
        mask = ~16'h0008;
        next_cycle(); pin[3] = 1'b1;
        @(negedge clk); check("R8 after one edge", stat, 16'h0000);
        @(negedge clk); check("R8 after two edges", stat, 16'h0008);
        @(negedge clk); check("R1 irq raised", {15'd0, irq}, 16'h0001);
        #1 pin[3] = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 follows pin", stat, 16'h0000);
        @(negedge clk); check("R1 irq released", {15'd0, irq}, 16'h0000);

        // R6: latched one-cycle pulse is held, captured value frozen
        #1 latch = 16'h0008;
        pin[3] = 1'b1; next_cycle(); pin[3] = 1'b0;
        repeat (6) @(negedge clk);
        check("R6 held status", stat, 16'h0008);
        check("R6 frozen capture", inq, 16'h0000);
        // R10: read port 0 clears status at once, line one edge later
        #1 rd = 2'b01; next_cycle(); rd = 2'b00;
        check("R10 status cleared", stat, 16'h0000);
        check("R10 irq one more edge", {15'd0, irq}, 16'h0001);
        @(negedge clk); check("R10 irq released", {15'd0, irq}, 16'h0000);

        // R4: output pin 5 unmasked, toggled, never a source
        #1 latch = '0; dir = ~16'h0020; mask = ~16'h0020;
        for (int i = 0; i < 4; i++) begin next_cycle(); pin[5] = ~pin[5]; end
        repeat (3) @(negedge clk);
        check("R4 output pin status", stat, 16'h0000);
        check("R4 output pin irq", {15'd0, irq}, 16'h0000);

        // R5: reading port 1 leaves port 0 capture alone
        #1 dir = '1; mask = ~16'h0008; pin[3] = 1'b1; pin[5] = 1'b0;
        repeat (3) next_cycle();
        rd = 2'b10; next_cycle(); rd = 2'b00;
        check("R5 port0 untouched", inq & 16'h00FF, 16'h0000);
        check("R5 port0 still pending", stat, 16'h0008);
        rd = 2'b01; next_cycle(); rd = 2'b00;
        check("R5 port0 captured", inq & 16'h00FF, 16'h0008);

        // random phase, checked every cycle by the model
        for (int c = 0; c < 6000; c++) begin
            next_cycle();
            rd = '0;
            if ($urandom_range(7) == 0) pin[$urandom_range(15)] ^= 1'b1;
            if ($urandom_range(15) == 0) rd = 2'($urandom_range(3));
            if ($urandom_range(63) == 0) begin
                mask  = 16'($urandom) | 16'($urandom);
                dir   = 16'($urandom) | 16'($urandom);
                latch = 16'($urandom);
            end
        end
        next_cycle(); rd = '0;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule